// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial bus for a byte-addressed memory of 2^ADDR_W bytes. It samples the clock and data lines with the system clock, finds start and stop conditions, assembles bytes, and checks a device select byte against three strap inputs. After the select byte it takes a two-byte word address, after which it serves byte and multi-byte writes, current-address reads, random reads and sequential reads. The data line is driven only by pulling it low through an enable output. The storage array, the page buffer and the programming timer sit outside the block.

Toward the chip the block offers two valid/ready streams. The write stream carries one beat (address and data) per received data byte. A beat stays valid with its address and data unchanged until `wr_ready` is high on a clock edge. No buffering sits behind it: if the previous beat is still pending when the next data byte completes, the new byte is refused. The read request stream carries one address per byte the master is about to read. `rd_req_valid` and `rd_req_addr` stay put until `rd_req_ready`. The response comes back as a one-cycle `rd_rsp_valid` pulse with `rd_rsp_data` and has no back-pressure. It must arrive before the next falling edge of the bus clock.

A busy input from the programming logic makes the block decline its select byte. This lets the master poll until the internal write cycle is over. A persistent address pointer survives between transactions, so a read that sends no address continues after the last byte accessed.

Top module: `serial_mem_slave`

## Requirements
- R1: A select byte is acknowledged only if bits 7..4 equal 1010, bits 3..1 equal `strap_i[2:1:0]` in that order, and `busy_i` is low. Bit 0 picks the direction: 1 means read and 0 means write.
- R2: A start is the data line falling while the clock line is high. A start at any point, including in the middle of a byte, abandons the transfer and makes the next byte a select byte. An address that was only partly received does not change the pointer.
- R3: The block acknowledges a byte by holding `sda_oe` high (line pulled low) for the ninth clock, and releases it once that clock falls. `sda_oe` never changes while the bus clock is high.
- R4: After a write select byte, the next two bytes form the word address, high byte first, and each one is acknowledged. Bit 7 of the high byte is ignored, which gives a 15-bit pointer.
- R5: Each received data byte produces one write beat at the current pointer, after which the pointer goes up by one. The pointer wraps from 0x7FFF to 0x0000.
- R6: A write beat holds `wr_valid`, `wr_addr` and `wr_data` until it is accepted. A data byte that completes while the previous beat is still pending is not acknowledged and is dropped, and the block then waits for a start.
- R7: While `busy_i` is high when the select byte completes, no acknowledge is given. With `busy_i` low, the same byte is acknowledged.
- R8: A read select with no address returns the byte at the pointer, which is the last accessed address plus one, wrapping from 0x7FFF to 0x0000.
- R9: A write select, two address bytes, a repeated start and a read select return the byte at the given address.
- R10: In a read, each master acknowledge (data low in the ninth clock) is followed by the next byte at the next address, rolling over from 0x7FFF to 0x0000. A master no-acknowledge ends the read.
- R11: Read data leaves most significant bit first. Each byte sent is fetched through one request on the read request stream, which holds its address until it is accepted.
- R12: After a refused select byte, or after a stop, the block leaves the data line released and ignores all bus traffic, writes included, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| strap_i | input | 3 | Device select strap bits |
| busy_i | input | 1 | Internal write cycle in progress |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | ADDR_W | Write beat address |
| wr_data | output | 8 | Write beat data |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read request address |
| rd_rsp_valid | input | 1 | Read response strobe |
| rd_rsp_data | input | 8 | Read response byte |

## Verification
The bench aims at the places where the pointer moves. These include wrap at the top address for both reads and writes, a read with no address right after a sequential read, and an address cut short by a start. A design that got the pointer wrong would read or write the wrong location, or would take on a half-received address. Busy polling and select mismatches on both the code and the strap bits are driven, and a faulty design would acknowledge a byte it must refuse or act on bytes that follow a refusal. Write back-pressure is held across two data bytes to show that the pending beat stays frozen and that the second byte is refused rather than written over it.

// File: rtl/twm_pkg.sv
package twm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } twm_state_e;

  localparam logic [3:0] TWM_DEV_CODE = 4'b1010;
  localparam int         TWM_BYTE_W   = 8;
endpackage

// File: rtl/twm_line_sync.sv
module twm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [1:0] raw;
  logic [1:0] cur;
  logic [1:0] prv;

  assign raw = {scl_in, sda_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign cur[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv <= 2'b11;
    else        prv <= cur;
  end

  assign sda_lvl   = cur[0];
  assign scl_rise  = cur[1] & ~prv[1];
  assign scl_fall  = ~cur[1] & prv[1];
  assign start_evt = cur[1] & prv[1] & prv[0] & ~cur[0];
  assign stop_evt  = cur[1] & prv[1] & ~prv[0] & cur[0];
endmodule

// File: rtl/twm_addr_ptr.sv
module twm_addr_ptr #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/twm_rd_port.sv
module twm_rd_port #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [ADDR_W-1:0] ptr,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [7:0]        rd_rsp_data,
  output logic              taken,
  output logic [7:0]        buf_q
);
  assign taken = rd_req_valid & rd_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_req_valid <= 1'b0;
      rd_req_addr  <= '0;
    end else if (issue) begin
      rd_req_valid <= 1'b1;
      rd_req_addr  <= ptr;
    end else if (taken) begin
      rd_req_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            buf_q <= 8'hFF;
    else if (rd_rsp_valid) buf_q <= rd_rsp_data;
  end
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import twm_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [7:0]        rd_rsp_data
);
  localparam int HI_W = ADDR_W - TWM_BYTE_W;

  logic sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

  twm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  twm_state_e       st_q, nxt_q, dec_nxt;
  logic [3:0]       cnt_q;
  logic [7:0]       sh_q;
  logic [HI_W-1:0]  hi_q;
  logic             ack_q, dec_ack, oe_q;
  logic             rx_state, byte_done, sel_hit;
  logic             issue_rd, beat_new, ptr_load, hi_load;
  logic             rd_taken;
  logic [7:0]       rd_buf;
  logic [7:0]       byte_in;
  logic [ADDR_W-1:0] ptr;

  assign byte_in   = {sh_q[6:0], sda_lvl};
  assign rx_state  = (st_q == ST_DEV) || (st_q == ST_AHI) ||
                     (st_q == ST_ALO) || (st_q == ST_WDAT);
  assign byte_done = scl_rise && (cnt_q == 4'd7) && rx_state;
  assign sel_hit   = (byte_in[7:4] == TWM_DEV_CODE) &&
                     (byte_in[3:1] == strap_i) && !busy_i;

  // Per-byte decisions taken when the eighth bit has been sampled.
  always_comb begin
    dec_ack  = 1'b0;
    dec_nxt  = ST_IDLE;
    issue_rd = 1'b0;
    beat_new = 1'b0;
    ptr_load = 1'b0;
    hi_load  = 1'b0;
    if (byte_done) begin
      unique case (st_q)
        ST_DEV: begin
          dec_ack  = sel_hit;
          dec_nxt  = byte_in[0] ? ST_RDAT : ST_AHI;
          issue_rd = sel_hit && byte_in[0];
        end
        ST_AHI: begin
          dec_ack = 1'b1;
          dec_nxt = ST_ALO;
          hi_load = 1'b1;
        end
        ST_ALO: begin
          dec_ack  = 1'b1;
          dec_nxt  = ST_WDAT;
          ptr_load = 1'b1;
        end
        default: begin
          dec_ack  = !(wr_valid && !wr_ready);
          dec_nxt  = ST_WDAT;
          beat_new = dec_ack;
        end
      endcase
    end else if (scl_rise && (cnt_q == 4'd8) && (st_q == ST_RDAT) && !sda_lvl) begin
      issue_rd = 1'b1;
    end
  end

  twm_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(ptr_load), .load_val({hi_q, byte_in}),
    .inc(beat_new | rd_taken), .ptr(ptr)
  );

  twm_rd_port #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .issue(issue_rd), .ptr(ptr),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .taken(rd_taken), .buf_q(rd_buf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_q <= '0;
    else if (hi_load) hi_q <= byte_in[HI_W-1:0];
  end

  // Write beat stream: held until accepted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (beat_new) begin
      wr_valid <= 1'b1;
      wr_addr  <= ptr;
      wr_data  <= byte_in;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  // Bit and byte sequencer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      nxt_q <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      ack_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (start_evt) begin
      st_q  <= ST_DEV;
      cnt_q <= '0;
      ack_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (stop_evt) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (st_q != ST_IDLE) begin
      if (scl_rise) begin
        if (cnt_q < 4'd8) begin
          cnt_q <= cnt_q + 1'b1;
          if (rx_state) sh_q <= byte_in;
          if (byte_done) begin
            ack_q <= dec_ack;
            nxt_q <= dec_nxt;
          end
        end else if (cnt_q == 4'd8) begin
          cnt_q <= 4'd9;
          if (st_q == ST_RDAT) begin
            ack_q <= !sda_lvl;
            nxt_q <= ST_RDAT;
          end
        end
      end else if (scl_fall) begin
        if ((st_q == ST_RDAT) && (cnt_q >= 4'd1) && (cnt_q <= 4'd7)) begin
          sh_q <= {sh_q[6:0], 1'b0};
          oe_q <= ~sh_q[6];
        end else if (cnt_q == 4'd8) begin
          oe_q <= (st_q != ST_RDAT) && ack_q;
        end else if (cnt_q == 4'd9) begin
          cnt_q <= '0;
          if (!ack_q) begin
            st_q <= ST_IDLE;
            oe_q <= 1'b0;
          end else begin
            st_q <= nxt_q;
            if (nxt_q == ST_RDAT) begin
              sh_q <= rd_buf;
              oe_q <= ~rd_buf[7];
            end else begin
              oe_q <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/twm_checker.sv
module twm_checker
  import twm_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input twm_state_e        st_q
);
  assert_oe_quiet_scl_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scl_i |-> $stable(sda_oe));

  assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  assert_idle_released_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !sda_oe);

  assert_beat_from_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> (st_q == ST_WDAT));
endmodule

bind serial_mem_slave twm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_req_addr(rd_req_addr), .st_q(st_q)
);

// File: tb/serial_mem_slave_bench.sv
`timescale 1ns/1ps
module serial_mem_slave_bench;
  localparam int AW = 15;
  localparam int Q  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  logic [2:0] strap = 3'b011;
  logic busy = 1'b0;
  logic wr_stall = 1'b0;
  logic wr_valid, wr_ready;
  logic [AW-1:0] wr_addr, rd_req_addr;
  logic [7:0] wr_data;
  logic rd_req_valid, rd_req_ready;
  logic rd_rsp_valid = 1'b0;
  logic [7:0] rd_rsp_data = 8'h00;
  logic [1:0] rdy_cnt = 2'b00;

  logic [7:0]    mem [0:255];
  logic [AW-1:0] wlog_a [0:15];
  logic [7:0]    wlog_d [0:15];
  int            wcount = 0;
  int            n_chk = 0, n_fail = 0;
  bit            done = 0;

  always #2.5 clk = ~clk;

  assign sda_bus      = sda_m & ~sda_oe;
  assign wr_ready     = !wr_stall;
  assign rd_req_ready = (rdy_cnt == 2'b11);

  serial_mem_slave u_serial_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_i(strap), .busy_i(busy),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data)
  );

  function automatic logic [7:0] model(input logic [AW-1:0] a);
    return mem[a[7:0]] ^ {1'b0, a[14:8]};
  endfunction

  always @(posedge clk) begin
    rdy_cnt      <= rdy_cnt + 2'd1;
    rd_rsp_valid <= rd_req_valid && rd_req_ready;
    rd_rsp_data  <= model(rd_req_addr);
    if (wr_valid && wr_ready) begin
      mem[wr_addr[7:0]] <= wr_data ^ {1'b0, wr_addr[14:8]};
      if (wcount < 16) begin
        wlog_a[wcount] <= wr_addr;
        wlog_d[wcount] <= wr_data;
      end
      wcount <= wcount + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl_m = 1'b1; tick(Q);
      b = {b[6:0], sda_bus};
      tick(Q); scl_m = 1'b0;
    end
    tick(Q);
    sda_m = mack ? 1'b0 : 1'b1; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] sel(input logic rd);
    return {4'b1010, strap, rd};
  endfunction

  task automatic set_addr(input logic [15:0] a, input string tag);
    logic ak;
    bus_start;
    send_byte(sel(1'b0), ak); check(ak, {tag, " R1 select"}, ak, 1);
    send_byte(a[15:8], ak);   check(ak, {tag, " R4 addr hi"}, ak, 1);
    send_byte(a[7:0], ak);    check(ak, {tag, " R4 addr lo"}, ak, 1);
  endtask

  task automatic t_reset;
    check(sda_oe == 1'b0, "R3 reset line released", sda_oe, 0);
    check(wr_valid == 1'b0, "R6 reset no write beat", wr_valid, 0);
    check(rd_req_valid == 1'b0, "R11 reset no read request", rd_req_valid, 0);
  endtask

  task automatic t_byte_write;
    logic ak;
    int base;
    base = wcount;
    set_addr(16'h8123, "byte write");
    send_byte(8'h5A, ak); check(ak, "R5 data ack", ak, 1);
    tick(4);
    check(sda_oe == 1'b0, "R3 ack released after ninth clock", sda_oe, 0);
    bus_stop; tick(4);
    check(wcount == base + 1, "R5 one beat per byte", wcount - base, 1);
    check(wlog_a[base] == 15'h0123, "R4 address msb ignored", wlog_a[base], 15'h0123);
    check(wlog_d[base] == 8'h5A, "R5 beat data", wlog_d[base], 8'h5A);
  endtask

  task automatic t_cur_read(input logic [AW-1:0] exp_a, input string tag);
    logic ak;
    logic [7:0] d;
    bus_start;
    send_byte(sel(1'b1), ak); check(ak, {tag, " R8 read select ack"}, ak, 1);
    recv_byte(1'b0, d);
    check(d == model(exp_a), {tag, " R8 R11 current address data"}, d, model(exp_a));
    bus_stop;
  endtask

  task automatic t_random_read;
    logic ak;
    logic [7:0] d;
    set_addr(16'h0123, "random read");
    bus_start;
    send_byte(sel(1'b1), ak); check(ak, "R9 repeated start read ack", ak, 1);
    recv_byte(1'b0, d);
    check(d == 8'h5A, "R9 random read data", d, 8'h5A);
    bus_stop;
  endtask

  task automatic t_seq_wrap;
    logic ak;
    logic [7:0] d;
    logic [AW-1:0] a;
    set_addr(16'h7FFE, "seq read");
    bus_start;
    send_byte(sel(1'b1), ak);
    a = 15'h7FFE;
    for (int i = 0; i < 3; i++) begin
      recv_byte(i < 2, d);
      check(d == model(a), "R10 sequential byte with rollover", d, model(a));
      a = a + 1'b1;
    end
    bus_stop;
    t_cur_read(15'h0001, "after seq");
  endtask

  task automatic t_write_wrap;
    logic ak;
    logic [7:0] d;
    int base;
    base = wcount;
    set_addr(16'h7FFF, "write wrap");
    send_byte(8'h11, ak);
    send_byte(8'h22, ak);
    bus_stop; tick(4);
    check(wlog_a[base] == 15'h7FFF, "R5 first beat at top", wlog_a[base], 15'h7FFF);
    check(wlog_a[base+1] == 15'h0000, "R5 pointer wraps to zero", wlog_a[base+1], 0);
    set_addr(16'h0000, "write wrap readback");
    bus_start;
    send_byte(sel(1'b1), ak);
    recv_byte(1'b0, d);
    check(d == 8'h22, "R5 wrapped byte stored", d, 8'h22);
    bus_stop;
  endtask

  task automatic t_busy;
    logic ak;
    busy = 1'b1;
    bus_start;
    send_byte(sel(1'b0), ak); check(!ak, "R7 busy refuses select", ak, 0);
    bus_stop;
    busy = 1'b0;
    bus_start;
    send_byte(sel(1'b0), ak); check(ak, "R7 idle acknowledges select", ak, 1);
    bus_stop;
  endtask

  task automatic t_mismatch;
    logic ak;
    int base;
    base = wcount;
    bus_start;
    send_byte(8'hA0, ak); check(!ak, "R1 strap mismatch refused", ak, 0);
    send_byte(8'h00, ak); check(!ak, "R12 bytes ignored after refusal", ak, 0);
    send_byte(8'h10, ak);
    send_byte(8'h77, ak);
    bus_stop; tick(4);
    check(wcount == base, "R12 no write after refusal", wcount - base, 0);
    bus_start;
    send_byte(8'hB6, ak); check(!ak, "R1 code mismatch refused", ak, 0);
    bus_stop;
  endtask

  task automatic t_abort;
    logic ak;
    set_addr(16'h0040, "abort setup");
    bus_stop;
    bus_start;
    send_byte(sel(1'b0), ak);
    send_byte(8'h12, ak);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    t_cur_read(15'h0040, "R2 abort mid-address");
  endtask

  task automatic t_backpressure;
    logic ak;
    logic [7:0] d;
    int base;
    base = wcount;
    wr_stall = 1'b1;
    set_addr(16'h0080, "stall");
    send_byte(8'hA1, ak); check(ak, "R6 first byte accepted", ak, 1);
    send_byte(8'hA2, ak); check(!ak, "R6 second byte refused while pending", ak, 0);
    check(wr_valid && wr_addr == 15'h0080 && wr_data == 8'hA1,
          "R6 beat held while stalled", {wr_valid, wr_data}, {1'b1, 8'hA1});
    bus_stop;
    wr_stall = 1'b0; tick(4);
    check(wcount == base + 1 && wlog_d[base] == 8'hA1, "R6 single beat delivered",
          wcount - base, 1);
    set_addr(16'h0081, "stall readback");
    bus_start;
    send_byte(sel(1'b1), ak);
    recv_byte(1'b0, d);
    check(d == model(15'h0081), "R6 refused byte not written", d, model(15'h0081));
    bus_stop;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset;
    t_byte_write;
    t_cur_read(15'h0124, "cur read");
    t_random_read;
    t_seq_wrap;
    t_write_wrap;
    t_busy;
    t_mismatch;
    t_abort;
    t_backpressure;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule